// File: doc/BRIEF.md
# Stereo Serial Audio Output Serializer

This block takes stereo PCM sample pairs from an upstream producer and shifts them out, one bit per bit-clock period, on a single serial data line. It also drives a word-select (frame clock) line. The bit clock itself comes from an external clock generator. The serializer sees it as a level that is synchronous to the system clock, detects its edges, and launches each data bit on the edge chosen by configuration. One frame carries one stereo pair: the first half-frame carries the left channel and the second half-frame carries the right channel.

The configuration inputs select three things:
- the alignment of each sample inside its half-frame (left-justified, standard delayed-by-one, or right-justified);
- the frame length (32, 48 or 64 bit-clock periods);
- the sample width (16 or 24 bits), and the polarity of each clock.

All configuration is captured at each frame start, so a change only takes effect on a frame boundary.

The producer offers a pair on a valid/ready handshake. At most one pair is taken per frame, at the frame-start launch. When a frame starts with no pair on offer, the frame is sent as zeros and a sticky underrun flag is raised. The hold input mutes the data line while the clocks keep running. It is meant to be asserted before output starts and during a stop.

Top module: `audio_serializer`

## Requirements
- R1: After reset, sd_o is 0, ws_o is 0, in_ready is 0 and underrun_o is 0, and the captured configuration is left-justified, 32-slot frame, 16-bit width, with both polarities normal.
- R2: With cfg_align = 0 (left-justified), the sample MSB occupies slot 0 of its half-frame. The bits follow MSB first, and every slot past the sample width is driven 0.
- R3: With cfg_align = 1 (standard delayed), every bit moves one slot later than in left-justified mode. The MSB occupies slot 1 of its half-frame, and the right-channel LSB occupies slot 0 of the following frame.
- R4: With cfg_align = 2 (right-justified), the sample LSB occupies the last slot of its half-frame, and the slots before the MSB are driven 0.
- R5: The frame length is set by cfg_frame: code 0 gives 32 slots, code 2 gives 48 and code 3 gives 64. The reserved code 1 gives 32. ws_o is at its left level for the first half of the frame and at its right level for the second half.
- R6: With cfg_wide = 0, bits [15:0] of each input word are sent (16-bit samples). With cfg_wide = 1, bits [23:0] are sent (24-bit samples).
- R7: With cfg_ws_inv = 0, ws_o is 0 during the left half-frame. With cfg_ws_inv = 1, ws_o is 1 during the left half-frame.
- R8: With cfg_bclk_inv = 0, data and ws_o change after a falling edge of bclk, so a receiver samples on the rising edge. With cfg_bclk_inv = 1, they change after a rising edge and are sampled on the falling edge.
- R9: in_ready is high only in the single cycle of the frame-start launch. A pair is taken when in_valid and in_ready are both high, and pairs appear on the line in the order they were taken, one per frame.
- R10: While hold is 1, sd_o is 0, no pair is accepted, underrun_o does not rise, and ws_o keeps toggling.
- R11: At a frame start with hold at 0 and in_valid at 0, the whole frame is sent as zeros and underrun_o becomes 1. It stays 1 until reset, even after data resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock level from the clock generator, synchronous to clk |
| cfg_align | input | 2 | Alignment: 0 left-justified, 1 delayed-by-one, 2 right-justified |
| cfg_frame | input | 2 | Frame length code: 0 or 1 gives 32, 2 gives 48, 3 gives 64 slots |
| cfg_wide | input | 1 | Sample width: 0 gives 16 bits, 1 gives 24 bits |
| cfg_bclk_inv | input | 1 | Launch data on rising (1) instead of falling (0) bclk edges |
| cfg_ws_inv | input | 1 | Invert the word-select level |
| hold | input | 1 | Mute the data line and block sample acceptance |
| in_valid | input | 1 | A stereo pair is on offer |
| in_ready | output | 1 | Frame-start launch: the offered pair is taken this cycle |
| in_left | input | SAMPLE_W | Left-channel sample, right-aligned in the word |
| in_right | input | SAMPLE_W | Right-channel sample, right-aligned in the word |
| sd_o | output | 1 | Serial data out |
| ws_o | output | 1 | Word-select (frame clock) out |
| underrun_o | output | 1 | Sticky flag: a frame started with no pair on offer |

## Verification
The hardest state to reach is the delayed-by-one alignment around a stop. There, the last right-channel bit of a pair leaves in slot 0 of the next frame, so muting too early would cut it off. The stimulus follows each real sequence with two all-zero pairs before raising hold. The monitor rebuilds every frame from the line, starting one slot after each word-select edge, and compares it with the whole expected frame, including the zero slots. A frame is skipped only when it is all zeros and no frame is pending, or when it is all zeros and the pending frame is itself nonzero. A frame that is silently lost therefore still shows up as a queue left non-empty.

// File: rtl/audio_serializer.sv
module audio_serializer #(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic [1:0]          cfg_align,
  input  logic [1:0]          cfg_frame,
  input  logic                cfg_wide,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_ws_inv,
  input  logic                hold,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                sd_o,
  output logic                ws_o,
  output logic                underrun_o
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic                bclk_q, launch, last, frame_start;
  logic [1:0]          align_q, frame_q;
  logic                wide_q, binv_q, winv_q;
  logic [6:0]          slot, flen, half, pos, idx, wsel, bit_ix;
  logic [SAMPLE_W-1:0] cur_l, cur_r, prev_r, word;
  logic                dly, wrapped, rside, bit_v;

  assign launch = binv_q ? (bclk & ~bclk_q) : (~bclk & bclk_q);
  assign flen = (frame_q == 2'd2) ? 7'd48 : (frame_q == 2'd3) ? 7'd64 : 7'd32;
  assign half = flen >> 1;
  assign last = (slot == flen - 7'd1);
  assign frame_start = launch & last;
  assign in_ready = frame_start & ~hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q     <= 1'b0;
      slot       <= '0;
      align_q    <= 2'd0;
      frame_q    <= 2'd0;
      wide_q     <= 1'b0;
      binv_q     <= 1'b0;
      winv_q     <= 1'b0;
      cur_l      <= '0;
      cur_r      <= '0;
      prev_r     <= '0;
      underrun_o <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (launch) slot <= last ? 7'd0 : slot + 7'd1;
      if (frame_start) begin
        align_q <= cfg_align;
        frame_q <= cfg_frame;
        wide_q  <= cfg_wide;
        binv_q  <= cfg_bclk_inv;
        winv_q  <= cfg_ws_inv;
        prev_r  <= cur_r;
        if (hold || !in_valid) begin
          cur_l <= '0;
          cur_r <= '0;
        end else begin
          cur_l <= in_left;
          cur_r <= in_right;
        end
        if (!hold && !in_valid) underrun_o <= 1'b1;
      end
    end
  end

  assign dly     = (align_q == 2'd1);
  assign wrapped = dly & (slot == 7'd0);
  assign pos     = wrapped ? flen - 7'd1 : slot - {6'd0, dly};
  assign rside   = (pos >= half);
  assign idx     = rside ? pos - half : pos;
  assign word    = rside ? (wrapped ? prev_r : cur_r) : cur_l;
  assign wsel    = wide_q ? 7'(WIDE_W) : 7'(NARROW_W);

  always_comb begin
    bit_v  = 1'b0;
    bit_ix = '0;
    if (align_q == 2'd2) begin
      if (idx + wsel >= half) begin
        bit_ix = half - 7'd1 - idx;
        bit_v  = word[bit_ix[IDX_W-1:0]];
      end
    end else if (idx < wsel) begin
      bit_ix = wsel - 7'd1 - idx;
      bit_v  = word[bit_ix[IDX_W-1:0]];
    end
  end

  assign sd_o = ~hold & bit_v;
  assign ws_o = (slot >= half) ^ winv_q;
endmodule

module serializer_checker (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic in_valid,
  input logic in_ready,
  input logic underrun_o
);
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o); // R11
  AST_NO_UNDERRUN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !underrun_o) |=> !underrun_o); // R10
  AST_UNDERRUN_NEEDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> !$past(in_valid)); // R11
endmodule

bind audio_serializer serializer_checker chk_i (.*);

// File: tb/audio_serializer_test.sv
module audio_serializer_test;
  logic clk = 0, rst_n = 0, bclk = 0;
  logic [1:0] cfg_align = 0, cfg_frame = 0;
  logic cfg_wide = 0, cfg_bclk_inv = 0, cfg_ws_inv = 0, hold = 1, in_valid = 0;
  logic [23:0] in_left = 0, in_right = 0;
  logic in_ready, sd_o, ws_o, underrun_o;

  audio_serializer uut (.*);

  always #4 clk = ~clk;

  int vecs = 0, fails = 0, acc_cnt = 0, hold_ones = 0, any_ones = 0, ws_flips = 0;
  bit done = 0;
  int b_al = 0, b_fl = 32, b_w = 16, b_bi = 0, b_wi = 0;
  string tag = "R2";
  logic [63:0] expq[$];
  logic [63:0] hist = 0;
  int pos = 100;
  logic prev_ws = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] frame_bits(input logic [23:0] l, input logic [23:0] r,
                                             input int al, input int fl, input int w);
    logic [63:0] v = 0;
    int h = fl / 2;
    for (int p = 0; p < fl; p++) begin
      int ix = (p >= h) ? p - h : p;
      logic [23:0] wd = (p >= h) ? r : l;
      logic b = 0;
      if (al == 2) begin
        if (ix >= h - w) b = wd[h-1-ix];
      end else if (ix < w) b = wd[w-1-ix];
      v[fl-1-p] = b;
    end
    return v;
  endfunction

  always @(posedge clk) if (in_valid && in_ready) acc_cnt++;

  task automatic sample_line();
    logic [63:0] mask, got;
    int dly = (b_al == 1) ? 1 : 0;
    if (ws_o !== prev_ws) ws_flips++;
    if (hold && sd_o) hold_ones++;
    if (sd_o) any_ones++;
    if (ws_o == b_wi[0] && prev_ws != b_wi[0]) pos = 0;
    else if (pos < 100) pos++;
    if (pos == dly) begin
      mask = (b_fl == 64) ? '1 : ((64'd1 << b_fl) - 64'd1);
      got = hist & mask;
      if (expq.size() > 0) begin
        if (got == expq[0]) begin
          chk({tag, " frame"}, got, expq[0]);
          void'(expq.pop_front());
        end else if (got != 0 || expq[0] == 0) begin
          chk({tag, " frame"}, got, expq[0]);
          void'(expq.pop_front());
        end
      end else if (got != 0) chk({tag, " unexpected frame"}, got, 64'd0);
    end
    hist = {hist[62:0], sd_o};
    prev_ws = ws_o;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      repeat (2) @(negedge clk);
      if ((bclk == 1'b0 && b_bi == 0) || (bclk == 1'b1 && b_bi == 1)) sample_line();
      bclk = ~bclk;
    end
  end

  task automatic send_pair(input logic [23:0] l, input logic [23:0] r, input bit track);
    in_left = l; in_right = r; in_valid = 1;
    forever begin
      @(negedge clk); #1;
      if (in_ready) break;
    end
    @(posedge clk);
    if (track) expq.push_back(frame_bits(l, r, b_al, b_fl, b_w));
    #1 in_valid = 0;
  endtask

  task automatic session(input int al, input int code, input int w24, input int bi, input int wi,
                         input string t, input int seed);
    int a0, f0;
    @(posedge clk); #1;
    hold = 1; in_valid = 0;
    cfg_align = 2'(al); cfg_frame = 2'(code); cfg_wide = w24[0];
    cfg_bclk_inv = bi[0]; cfg_ws_inv = wi[0];
    b_al = al; b_fl = (code == 2) ? 48 : (code == 3) ? 64 : 32;
    b_w = w24 ? 24 : 16; b_bi = bi; b_wi = wi; tag = t;
    repeat (800) @(posedge clk);
    #1;
    in_valid = 1; in_left = 24'h5A5A5A; in_right = 24'hA5A5A5;
    a0 = acc_cnt; hold_ones = 0; f0 = ws_flips;
    repeat (520) @(posedge clk);
    chk("R10 no accept in hold", 64'(acc_cnt - a0), 64'd0);
    chk("R10 muted in hold", 64'(hold_ones), 64'd0);
    chk("R10 ws toggles in hold", 64'(ws_flips > f0), 64'd1);
    #1 hold = 0;
    for (int k = 0; k < 3; k++)
      send_pair(24'hC30000 ^ 24'(seed * 24'h1357 + k * 24'h2461) | 24'h1,
                24'h3C0000 ^ 24'(seed * 24'h0B7D + k * 24'h7319) | 24'h1, 1);
    send_pair(0, 0, 0);
    send_pair(0, 0, 0);
    hold = 1;
    repeat (600) @(posedge clk);
    chk({"R9 all pairs out ", t}, 64'(expq.size()), 64'd0);
    expq.delete();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1 sd_o", 64'(sd_o), 0);
    chk("R1 ws_o", 64'(ws_o), 0);
    chk("R1 in_ready", 64'(in_ready), 0);
    chk("R1 underrun_o", 64'(underrun_o), 0);
    rst_n = 1;
    session(0, 1, 0, 0, 0, "R2 R5 R6", 1);
    session(1, 0, 0, 0, 0, "R3 R5", 2);
    session(2, 3, 1, 0, 0, "R4 R6", 3);
    session(1, 2, 1, 1, 1, "R3 R7 R8", 4);
    session(0, 3, 1, 0, 1, "R2 R7", 5);
    session(2, 2, 0, 1, 0, "R4 R8 R5", 6);
    chk("R10 hold kept underrun low", 64'(underrun_o), 0);
    session(0, 0, 0, 0, 0, "R2", 7);
    @(posedge clk); #1;
    hold = 0; in_valid = 0; any_ones = 0;
    repeat (400) @(posedge clk);
    chk("R11 underrun raised", 64'(underrun_o), 1);
    chk("R11 zeros on gap", 64'(any_ones), 0);
    tag = "R11 resume";
    send_pair(24'h00F00D, 24'h00BEEF, 1);
    send_pair(0, 0, 0);
    send_pair(0, 0, 0);
    hold = 1;
    repeat (300) @(posedge clk);
    chk("R11 resume drained", 64'(expq.size()), 0);
    chk("R11 underrun sticky", 64'(underrun_o), 1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vecs++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule